// File: doc/BRIEF.md
# Clock Generator Interrupt Status Unit

This block gathers the three interrupt sources of a clock and reset generator and drives one combined request line. The first source is a programmable periodic tick made from the reference clock. The second is any change of the PLL lock indication. The third is any change of the self-clock (backup clock) state. Software reaches three registers over a small synchronous bus. One holds the sticky event flags, which are cleared by writing 1. One holds the per-source enables. One holds the tick period select.

The PLL lock indication and the clock-fault inputs are asynchronous, so each passes through a two-flop synchronizer first. The lock and self-clock flags then fire on every transition of their state, in both directions. They do not fire on a level.

The block tracks the self-clock state itself. The state is entered on a clock-quality failure, on a clock-monitor failure, or on loss of the external clock while the monitor is armed. It is left when the quality check reports a good clock. The state changes only while the self-clock enable is high. In pseudo-stop the tick counter freezes unless the prescaler-run bit is set. With that bit set, the tick can wake the system periodically.

Top module: `clkirq_top`

## Requirements
- R1: With a nonzero period select S (bus address 2, 7 bits), the tick flag (flag bit 0) sets P = (S[3:0]+1)·2^(S[6:4]+RTI_BASE) cycles after the select write, and again every P cycles after that. A write to the select restarts the count from zero.
- R2: A select of 0 holds the tick counter cleared, and no tick flag is ever raised.
- R3: While pstop is 1 and pre is 0, the tick counter holds its value. Once pre is 1 it resumes, and the tick comes P counted cycles after the last restart.
- R4: Every change of lock_raw sets the lock flag (bit 1), for a rise and for a fall. The flag is readable on the third clock edge after the input changes.
- R5: While scme is 1, scm_active rises on qual_fail_raw, on mon_fail_raw, or on (cme AND ext_loss_raw). It falls on qual_pass_raw when no entry cause is present. Each change sets the self-clock flag (bit 2) on the same edge that scm_active changes, the third edge after the input.
- R6: While scme is 0, scm_active does not change and the self-clock flag is not set.
- R7: With cme at 0, ext_loss_raw has no effect on scm_active or on the self-clock flag.
- R8: A flag bit clears only when a 1 is written to that bit at bus address 0. Writing 0, or writing 1 to another bit, leaves it set.
- R9: If an event and a write-1 clear of the same flag fall in the same cycle, the flag stays set.
- R10: irq_req is the OR over the three sources of (flag AND enable). The enable register is at bus address 1 and uses the flag bit positions.
- R11: After reset the flags, enables, select, scm_active and irq_req are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 flags, 1 enables, 2 period select) |
| bus_wdata | input | 7 | Write data |
| bus_rdata | output | 7 | Read data for bus_addr |
| lock_raw | input | 1 | PLL lock indication, asynchronous |
| qual_fail_raw | input | 1 | Clock-quality check failed, asynchronous |
| mon_fail_raw | input | 1 | Clock-monitor failure, asynchronous |
| ext_loss_raw | input | 1 | External clock lost, asynchronous |
| qual_pass_raw | input | 1 | Clock-quality check passed, asynchronous |
| scme | input | 1 | Self-clock state changes allowed |
| cme | input | 1 | Clock monitor armed |
| pstop | input | 1 | Pseudo-stop mode active |
| pre | input | 1 | Keep tick counter running in pseudo-stop |
| scm_active | output | 1 | Self-clock state |
| irq_req | output | 1 | Combined interrupt request |

## Verification
The tick divider is driven with a table of select values. The table covers both fields at their low values and a mix of mantissa and exponent, so an error in the field split, the +1 term or the shift base changes the measured period. Each value is checked one cycle before and at the expected tick, and again for the next period. Lock is toggled in both directions, and the self-clock state is entered once through each of the three causes. These patterns separate true change detection from level detection and show whether a cause is wired to the wrong input. Directed cases cover a clear that coincides with an event, partial and zero writes to the flag register, the gating by scme and cme, and the pseudo-stop freeze.

// File: rtl/clkirq_pkg.sv
package clkirq_pkg;
  localparam int NSRC   = 3;
  localparam int SRC_TICK = 0;
  localparam int SRC_LOCK = 1;
  localparam int SRC_SCM  = 2;

  localparam int SEL_W  = 7;
  localparam int BUS_W  = SEL_W;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_FLAG = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_EN   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_SEL  = 2'd2;

  // positions of the asynchronous inputs in the synchronizer bank
  localparam int SY_LOCK  = 0;
  localparam int SY_QFAIL = 1;
  localparam int SY_MFAIL = 2;
  localparam int SY_XLOSS = 3;
  localparam int SY_QPASS = 4;
  localparam int NSYNC    = 5;

  // tick period in reference cycles: (mantissa+1) shifted by (exponent+base)
  function automatic logic [31:0] rti_period(input logic [SEL_W-1:0] sel, input int base);
    logic [31:0] mant;
    int          sh;
    mant = {28'd0, sel[3:0]} + 32'd1;
    sh   = int'(sel[6:4]) + base;
    return mant << sh;
  endfunction
endpackage

// File: rtl/clkirq_sync.sv
module clkirq_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_raw,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_raw;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/clkirq_rti.sv
module clkirq_rti
  import clkirq_pkg::*;
#(
  parameter int RTI_BASE = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic             sel_load,
  input  logic             halt,
  output logic             tick
);
  localparam int CNT_W = 11 + RTI_BASE;

  logic [31:0]      period;
  logic [CNT_W-1:0] last_cnt;
  logic [CNT_W-1:0] cnt_q;
  logic             run;

  assign period   = rti_period(sel, RTI_BASE);
  assign last_cnt = CNT_W'(period - 32'd1);
  assign run      = (sel != '0) && !halt;
  assign tick     = run && (cnt_q == last_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (sel_load || sel == '0)  cnt_q <= '0;
    else if (run)                    cnt_q <= tick ? '0 : cnt_q + 1'b1;
  end

  // R1: counter never reaches the period
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != '0) |-> (32'(cnt_q) < period));

  // R3: a halted counter keeps its value
  p_halt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(halt) && !$past(sel_load) && $past(sel) == sel) |-> $stable(cnt_q));
endmodule

// File: rtl/clkirq_evt.sv
module clkirq_evt (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_s,
  input  logic qfail_s,
  input  logic mfail_s,
  input  logic xloss_s,
  input  logic qpass_s,
  input  logic scme,
  input  logic cme,
  output logic lock_evt,
  output logic scm_evt,
  output logic scm_active
);
  logic lock_q;
  logic scm_q;
  logic enter_cause;
  logic leave_ok;

  assign lock_evt    = lock_s ^ lock_q;
  assign enter_cause = qfail_s | mfail_s | (cme & xloss_s);
  assign leave_ok    = qpass_s & ~enter_cause;
  assign scm_evt     = scme & (scm_q ? leave_ok : enter_cause);
  assign scm_active  = scm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      scm_q  <= 1'b0;
    end else begin
      lock_q <= lock_s;
      scm_q  <= scm_q ^ scm_evt;
    end
  end

  // R6: no self-clock change while disabled
  p_scm_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(scme) |-> $stable(scm_q));

  // R7: external-clock loss alone cannot enter with the monitor off
  p_xloss_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cme && !qfail_s && !mfail_s && !scm_q) |=> !scm_q);

  // R5: leaving needs a good quality result
  p_exit_needs_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scm_q) |-> $past(qpass_s && scme));
endmodule

// File: rtl/clkirq_regs.sv
module clkirq_regs
  import clkirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  input  logic [NSRC-1:0]   set_vec,
  output logic [NSRC-1:0]   flags,
  output logic [NSRC-1:0]   enables,
  output logic [SEL_W-1:0]  sel,
  output logic              sel_load,
  output logic              irq
);
  logic [NSRC-1:0] flags_q;
  logic [NSRC-1:0] en_q;
  logic [SEL_W-1:0] sel_q;
  logic [NSRC-1:0] clr_vec;

  assign clr_vec  = (wr && addr == ADDR_FLAG) ? wdata[NSRC-1:0] : '0;
  assign sel_load = wr && (addr == ADDR_SEL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      en_q    <= '0;
      sel_q   <= '0;
    end else begin
      flags_q <= (flags_q & ~clr_vec) | set_vec;
      if (wr && addr == ADDR_EN) en_q <= wdata[NSRC-1:0];
      if (sel_load)              sel_q <= wdata[SEL_W-1:0];
    end
  end

  always_comb begin
    case (addr)
      ADDR_FLAG: rdata = BUS_W'(flags_q);
      ADDR_EN:   rdata = BUS_W'(en_q);
      ADDR_SEL:  rdata = BUS_W'(sel_q);
      default:   rdata = '0;
    endcase
  end

  assign flags   = flags_q;
  assign enables = en_q;
  assign sel     = sel_q;
  assign irq     = |(flags_q & en_q);

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    // R8: a flag falls only after a write of 1 to its bit
    p_w1c_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flags_q[i]) |-> $past(wr && addr == ADDR_FLAG && wdata[i]));
    // R9: an event always leaves its flag set
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(set_vec[i]) |-> flags_q[i]);
  end

  // R10: no request with every source disabled
  p_irq_needs_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq);
endmodule

// File: rtl/clkirq_top.sv
module clkirq_top
  import clkirq_pkg::*;
#(
  parameter int RTI_BASE    = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              lock_raw,
  input  logic              qual_fail_raw,
  input  logic              mon_fail_raw,
  input  logic              ext_loss_raw,
  input  logic              qual_pass_raw,
  input  logic              scme,
  input  logic              cme,
  input  logic              pstop,
  input  logic              pre,
  output logic              scm_active,
  output logic              irq_req
);
  logic [NSYNC-1:0] raw_vec;
  logic [NSYNC-1:0] syn_vec;
  logic             lock_evt;
  logic             scm_evt;
  logic             tick_evt;
  logic             halt;
  logic [NSRC-1:0]  set_vec;
  logic [NSRC-1:0]  flags;
  logic [NSRC-1:0]  enables;
  logic [SEL_W-1:0] sel;
  logic             sel_load;

  always_comb begin
    raw_vec           = '0;
    raw_vec[SY_LOCK]  = lock_raw;
    raw_vec[SY_QFAIL] = qual_fail_raw;
    raw_vec[SY_MFAIL] = mon_fail_raw;
    raw_vec[SY_XLOSS] = ext_loss_raw;
    raw_vec[SY_QPASS] = qual_pass_raw;
  end

  clkirq_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_raw(raw_vec), .q(syn_vec)
  );

  clkirq_evt u_evt (
    .clk(clk), .rst_n(rst_n),
    .lock_s(syn_vec[SY_LOCK]), .qfail_s(syn_vec[SY_QFAIL]),
    .mfail_s(syn_vec[SY_MFAIL]), .xloss_s(syn_vec[SY_XLOSS]),
    .qpass_s(syn_vec[SY_QPASS]), .scme(scme), .cme(cme),
    .lock_evt(lock_evt), .scm_evt(scm_evt), .scm_active(scm_active)
  );

  assign halt = pstop & ~pre;

  clkirq_rti #(.RTI_BASE(RTI_BASE)) u_rti (
    .clk(clk), .rst_n(rst_n), .sel(sel), .sel_load(sel_load),
    .halt(halt), .tick(tick_evt)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[SRC_TICK] = tick_evt;
    set_vec[SRC_LOCK] = lock_evt;
    set_vec[SRC_SCM]  = scm_evt;
  end

  clkirq_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .set_vec(set_vec),
    .flags(flags), .enables(enables), .sel(sel), .sel_load(sel_load),
    .irq(irq_req)
  );

  // R4: a detected lock change is visible in the flag register
  p_lock_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lock_evt) |-> flags[SRC_LOCK]);

  // R5: a self-clock change is visible in the flag register
  p_scm_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(scm_evt) |-> flags[SRC_SCM]);

  // R10: a request needs at least one enabled source
  p_irq_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (enables != '0));
endmodule

// File: tb/clkirq_top_tb.sv
module clkirq_top_tb;
  localparam int BASE = 2;
  localparam int NV   = 6;
  localparam logic [6:0] SEL_TAB [NV] = '{7'h01, 7'h10, 7'h23, 7'h0F, 7'h35, 7'h40};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [6:0] bus_wdata = '0;
  logic [6:0] bus_rdata;
  logic lock_raw = 0, qual_fail_raw = 0, mon_fail_raw = 0, ext_loss_raw = 0, qual_pass_raw = 0;
  logic scme = 0, cme = 0, pstop = 0, pre = 0;
  logic scm_active, irq_req;

  int nvec = 0;
  int nerr = 0;
  bit done = 0;

  always #5 clk = ~clk;

  clkirq_top #(.RTI_BASE(BASE)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lock_raw(lock_raw),
    .qual_fail_raw(qual_fail_raw), .mon_fail_raw(mon_fail_raw),
    .ext_loss_raw(ext_loss_raw), .qual_pass_raw(qual_pass_raw),
    .scme(scme), .cme(cme), .pstop(pstop), .pre(pre),
    .scm_active(scm_active), .irq_req(irq_req)
  );

  function automatic int exp_period(input logic [6:0] s);
    int p;
    p = int'(s[3:0]) + 1;
    for (int k = 0; k < int'(s[6:4]) + BASE; k++) p = p * 2;
    return p;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [6:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1;
    bus_wr = 1'b0; bus_addr = 2'd0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    bus_addr = a;
    #1;
    v = int'(bus_rdata);
    bus_addr = 2'd0;
  endtask

  task automatic flag_bit(input int b, output int v);
    int f;
    rd(2'd0, f);
    v = (f >> b) & 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    int v;
    int p;
    edges(3);
    rst_n = 1'b1;
    edges(2);

    // R11: reset state
    rd(2'd0, v); chk("R11 flags", v, 0);
    rd(2'd1, v); chk("R11 enables", v, 0);
    rd(2'd2, v); chk("R11 select", v, 0);
    chk("R11 scm_active", int'(scm_active), 0);
    chk("R11 irq_req", int'(irq_req), 0);

    // R1: period table
    for (int i = 0; i < NV; i++) begin
      p = exp_period(SEL_TAB[i]);
      wr(2'd2, SEL_TAB[i]);
      edges(p - 1); flag_bit(0, v); chk("R1 before first tick", v, 0);
      edges(1);     flag_bit(0, v); chk("R1 first tick", v, 1);
      wr(2'd0, 7'h01);
      edges(p - 2); flag_bit(0, v); chk("R1 before second tick", v, 0);
      edges(1);     flag_bit(0, v); chk("R1 second tick", v, 1);
      wr(2'd0, 7'h01);
    end

    // R2: select zero stops ticking
    wr(2'd2, 7'h00);
    wr(2'd0, 7'h07);
    edges(300); flag_bit(0, v); chk("R2 stopped", v, 0);

    // R3: pseudo-stop freeze, then resume with pre
    pstop = 1; pre = 0;
    wr(2'd2, 7'h01);
    edges(40); flag_bit(0, v); chk("R3 frozen", v, 0);
    pre = 1;
    edges(7); flag_bit(0, v); chk("R3 before resume tick", v, 0);
    edges(1); flag_bit(0, v); chk("R3 resume tick", v, 1);
    pstop = 0; pre = 0;
    wr(2'd2, 7'h00);
    wr(2'd0, 7'h07);

    // R4: lock rise and fall
    lock_raw = 1;
    edges(2); flag_bit(1, v); chk("R4 rise early", v, 0);
    edges(1); flag_bit(1, v); chk("R4 rise", v, 1);
    // R10: disabled source does not request
    chk("R10 masked", int'(irq_req), 0);
    wr(2'd1, 7'h02); chk("R10 enabled", int'(irq_req), 1);
    wr(2'd1, 7'h05); chk("R10 other enables", int'(irq_req), 0);
    // R8: zero write and other-bit write leave it set
    wr(2'd0, 7'h00); flag_bit(1, v); chk("R8 write zero", v, 1);
    wr(2'd0, 7'h05); flag_bit(1, v); chk("R8 other bits", v, 1);
    wr(2'd0, 7'h02); flag_bit(1, v); chk("R8 clear", v, 0);
    lock_raw = 0;
    edges(2); flag_bit(1, v); chk("R4 fall early", v, 0);
    edges(1); flag_bit(1, v); chk("R4 fall", v, 1);
    wr(2'd0, 7'h02);

    // R9: event and clear on the same edge
    lock_raw = 1;
    edges(2);
    wr(2'd0, 7'h02);
    flag_bit(1, v); chk("R9 set wins", v, 1);
    wr(2'd0, 7'h02); flag_bit(1, v); chk("R9 later clear", v, 0);

    // R6: disabled self-clock changes
    scme = 0; mon_fail_raw = 1;
    edges(6);
    chk("R6 no entry", int'(scm_active), 0);
    flag_bit(2, v); chk("R6 no flag", v, 0);
    mon_fail_raw = 0;
    edges(4);

    // R5: entry via monitor failure, exit via quality pass
    scme = 1; mon_fail_raw = 1;
    edges(2); chk("R5 entry early", int'(scm_active), 0);
    edges(1); chk("R5 entry mon", int'(scm_active), 1);
    flag_bit(2, v); chk("R5 entry flag", v, 1);
    mon_fail_raw = 0;
    wr(2'd0, 7'h04);
    edges(5); chk("R5 stays active", int'(scm_active), 1);
    // R6: disabled exit
    scme = 0; qual_pass_raw = 1;
    edges(6); chk("R6 no exit", int'(scm_active), 1);
    flag_bit(2, v); chk("R6 no exit flag", v, 0);
    scme = 1;
    edges(1); chk("R5 exit", int'(scm_active), 0);
    flag_bit(2, v); chk("R5 exit flag", v, 1);
    qual_pass_raw = 0;
    wr(2'd0, 7'h04);
    edges(4);

    // R5: entry via quality failure
    qual_fail_raw = 1;
    edges(3); chk("R5 entry qual", int'(scm_active), 1);
    qual_fail_raw = 0; qual_pass_raw = 1;
    edges(3); chk("R5 exit qual", int'(scm_active), 0);
    qual_pass_raw = 0;
    wr(2'd0, 7'h04);
    edges(4);

    // R7: external loss ignored with monitor off
    cme = 0; ext_loss_raw = 1;
    edges(6); chk("R7 ignored", int'(scm_active), 0);
    flag_bit(2, v); chk("R7 no flag", v, 0);
    ext_loss_raw = 0;
    edges(4);
    // R5: entry via external loss with monitor armed
    cme = 1; ext_loss_raw = 1;
    edges(3); chk("R5 entry loss", int'(scm_active), 1);
    wr(2'd1, 7'h04); chk("R10 scm request", int'(irq_req), 1);
    ext_loss_raw = 0;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule